// File: doc/BRIEF.md
# Bus Access Fault Checker

This block watches every request on a system bus: its address, its size, whether it reads or writes, and whether it is privileged. It tests each request against a memory map set by parameters. That map holds a code Flash window, a RAM window, a peripheral window cut into 4 KB blocks, a protected slice of RAM and a system region on the main bus. When a request breaks a rule, the block raises a bus error response in the same cycle. It also records why the request failed in sticky cause bits.

Software reads the cause bits through the status output. It clears them by writing ones through a small register port. One access can break several rules at once and set several cause bits together. A fault that arrives while an earlier cause is still recorded also sets a separate overflow bit. A one-cycle fault pulse follows each rejected request. The status register has a bus address of its own, and any read of that address is accepted whatever its size or privilege.

Top module: `bus_fault_chk`

## Requirements
- R1: A byte (size 0) or halfword (size 1) access to any peripheral block is flagged as wrong-size (status bit 0). The error response is asserted combinationally in the same cycle as the request.
- R2: A word (size 2) access whose address bits [1:0] are not zero is flagged as wrong-size (status bit 0), in any region.
- R3: An unprivileged write to a system peripheral block, to the system region on the main bus or to the protected RAM range is flagged as protection (status bit 1). Unprivileged reads of these targets are not flagged, and neither are privileged writes.
- R4: Within the peripheral window, an access whose offset inside its 4 KB block is above that block's last register offset is flagged as reserved (status bit 2). So is an access to a block index at or above the number of implemented blocks.
- R5: An access inside the Flash or RAM window but at or above base plus size is flagged as reserved (status bit 2).
- R6: One access sets every cause that applies, all in the same cycle.
- R7: A fault that arrives while any of status bits [2:0] is already set also sets the missed bit (status bit 3). A fault that arrives with bits [2:0] clear does not set it.
- R8: Status bits stay set until a register write with a one in that bit position clears them. If a new cause for a bit arrives in the same cycle as the clear, the bit stays set.
- R9: After each faulting request, `fault_o` is high for exactly the following cycle. The status output shows the new causes in that same cycle.
- R10: A read of the status register address is never flagged, whatever its size or privilege.
- R11: After reset the status is zero and `fault_o` is low. A legal access, or no request at all, leaves the status unchanged and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Byte address of the request |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write_i | input | 1 | 1 write, 0 read |
| req_priv_i | input | 1 | 1 privileged, 0 unprivileged |
| reg_wr_i | input | 1 | Status clear strobe |
| reg_wdata_i | input | 4 | Write-one-to-clear mask for status bits |
| req_err_o | output | 1 | Bus error response, same cycle as the request |
| fault_o | output | 1 | One-cycle pulse after a faulting request |
| status_o | output | 4 | {missed, reserved, protection, wrong-size} |

## Verification
A decode error in the map shows up at once, because `req_err_o` is combinational and rises or stays low in the same cycle as the offending or legal request. A wrong update of the sticky register shows one edge later, on `status_o` and `fault_o`, and it stays visible until a clear. So a lost clear, a dropped cause or a false missed bit is seen on the next status sample. The bench checks the status after every access and every clear. A corruption therefore cannot hide behind a later access.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int unsigned STAT_W   = 4;
  localparam int unsigned CAUSE_W  = 3;
  localparam int unsigned BIT_SIZE = 0;
  localparam int unsigned BIT_PROT = 1;
  localparam int unsigned BIT_RSVD = 2;
  localparam int unsigned BIT_MISS = 3;
  localparam int unsigned BLK_SHIFT = 12;
  localparam int unsigned OFS_W    = 12;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic flash_rsvd;
    logic ram_rsvd;
    logic prot_ram;
    logic apb_hit;
    logic apb_sys;
    logic apb_rsvd;
    logic ahb_sys;
    logic stat_hit;
  } map_hit_t;
endpackage

// File: rtl/bfc_decode.sv
module bfc_decode
  import bfc_pkg::*;
#(
  parameter logic [31:0] FLASH_BASE  = 32'h0800_0000,
  parameter logic [31:0] FLASH_WIN   = 32'h0800_0000,
  parameter logic [31:0] FLASH_SIZE  = 32'h0002_0000,
  parameter logic [31:0] RAM_BASE    = 32'h2000_0000,
  parameter logic [31:0] RAM_WIN     = 32'h1000_0000,
  parameter logic [31:0] RAM_SIZE    = 32'h0000_4000,
  parameter logic [31:0] PROT_BASE   = 32'h2000_3000,
  parameter logic [31:0] PROT_SIZE   = 32'h0000_1000,
  parameter logic [31:0] PERIPH_BASE = 32'h4000_0000,
  parameter int unsigned WIN_BLKS    = 16,
  parameter int unsigned NUM_BLK     = 4,
  parameter logic [NUM_BLK*OFS_W-1:0] LAST_OFS = {12'h100, 12'h3FC, 12'h07C, 12'h020},
  parameter logic [NUM_BLK-1:0] SYS_MASK = 4'b0010,
  parameter logic [31:0] SYS_BASE    = 32'hE000_0000,
  parameter logic [31:0] SYS_SIZE    = 32'h0000_1000,
  parameter logic [31:0] STAT_ADDR   = 32'h4000_3800
) (
  input  logic [31:0] addr_i,
  output map_hit_t    hit_o
);
  localparam int unsigned IDX_W = $clog2(WIN_BLKS);
  localparam int unsigned TOP_LO = BLK_SHIFT + IDX_W;
  localparam logic [31:0] FLASH_END = FLASH_BASE + FLASH_WIN;
  localparam logic [31:0] FLASH_TOP = FLASH_BASE + FLASH_SIZE;
  localparam logic [31:0] RAM_END   = RAM_BASE + RAM_WIN;
  localparam logic [31:0] RAM_TOP   = RAM_BASE + RAM_SIZE;
  localparam logic [31:0] PROT_END  = PROT_BASE + PROT_SIZE;
  localparam logic [31:0] SYS_END   = SYS_BASE + SYS_SIZE;

  logic             in_flash, in_ram, in_periph;
  logic [IDX_W-1:0] blk_idx;
  logic [OFS_W-1:0] blk_ofs;
  logic [NUM_BLK-1:0] blk_hit, blk_over;

  assign in_flash  = (addr_i >= FLASH_BASE) && (addr_i < FLASH_END);
  assign in_ram    = (addr_i >= RAM_BASE) && (addr_i < RAM_END);
  assign in_periph = addr_i[31:TOP_LO] == PERIPH_BASE[31:TOP_LO];
  assign blk_idx   = addr_i[BLK_SHIFT +: IDX_W];
  assign blk_ofs   = addr_i[OFS_W-1:0];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blk_hit[b]  = in_periph && (blk_idx == IDX_W'(b));
    assign blk_over[b] = blk_hit[b] && (blk_ofs > LAST_OFS[b*OFS_W +: OFS_W]);
  end

  always_comb begin
    hit_o            = '0;
    hit_o.flash_rsvd = in_flash && (addr_i >= FLASH_TOP);
    hit_o.ram_rsvd   = in_ram && (addr_i >= RAM_TOP);
    hit_o.prot_ram   = (addr_i >= PROT_BASE) && (addr_i < PROT_END);
    hit_o.apb_hit    = in_periph;
    hit_o.apb_sys    = |(blk_hit & SYS_MASK);
    hit_o.apb_rsvd   = (|blk_over) || (in_periph && (32'(blk_idx) >= NUM_BLK));
    hit_o.ahb_sys    = (addr_i >= SYS_BASE) && (addr_i < SYS_END);
    hit_o.stat_hit   = addr_i == STAT_ADDR;
  end
endmodule

// File: rtl/bfc_classify.sv
module bfc_classify
  import bfc_pkg::*;
(
  input  logic               valid_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         addr_lo_i,
  input  logic               write_i,
  input  logic               priv_i,
  input  map_hit_t           hit_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic word_acc, exempt;
  logic [CAUSE_W-1:0] raw;

  assign word_acc = acc_size_e'(size_i) == SZ_WORD;
  // own status register: reads always accepted
  assign exempt   = hit_i.stat_hit && !write_i;

  always_comb begin
    raw = '0;
    raw[BIT_SIZE] = (hit_i.apb_hit && !word_acc) || (word_acc && (addr_lo_i != 2'b00));
    raw[BIT_PROT] = !priv_i && write_i &&
                    (hit_i.apb_sys || hit_i.ahb_sys || hit_i.prot_ram);
    raw[BIT_RSVD] = hit_i.apb_rsvd || hit_i.flash_rsvd || hit_i.ram_rsvd;
    cause_o = (valid_i && !exempt) ? raw : '0;
  end
endmodule

// File: rtl/bfc_status.sv
module bfc_status
  import bfc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               clr_en_i,
  input  logic [STAT_W-1:0]  clr_mask_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               fault_o
);
  logic [STAT_W-1:0] stat_q, set_v, clr_v;
  logic any_fault, missed;

  assign any_fault = |cause_i;
  assign missed    = any_fault && (|stat_q[CAUSE_W-1:0]);
  assign set_v     = {missed, cause_i};
  assign clr_v     = clr_en_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      fault_o <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~clr_v) | set_v;  // set beats clear
      fault_o <= any_fault;
    end
  end

  assign status_o = stat_q;
endmodule

// File: rtl/bus_fault_chk.sv
module bus_fault_chk
  import bfc_pkg::*;
#(
  parameter logic [31:0] FLASH_BASE  = 32'h0800_0000,
  parameter logic [31:0] FLASH_WIN   = 32'h0800_0000,
  parameter logic [31:0] FLASH_SIZE  = 32'h0002_0000,
  parameter logic [31:0] RAM_BASE    = 32'h2000_0000,
  parameter logic [31:0] RAM_WIN     = 32'h1000_0000,
  parameter logic [31:0] RAM_SIZE    = 32'h0000_4000,
  parameter logic [31:0] PROT_BASE   = 32'h2000_3000,
  parameter logic [31:0] PROT_SIZE   = 32'h0000_1000,
  parameter logic [31:0] PERIPH_BASE = 32'h4000_0000,
  parameter int unsigned WIN_BLKS    = 16,
  parameter int unsigned NUM_BLK     = 4,
  parameter logic [NUM_BLK*OFS_W-1:0] LAST_OFS = {12'h100, 12'h3FC, 12'h07C, 12'h020},
  parameter logic [NUM_BLK-1:0] SYS_MASK = 4'b0010,
  parameter logic [31:0] SYS_BASE    = 32'hE000_0000,
  parameter logic [31:0] SYS_SIZE    = 32'h0000_1000,
  parameter logic [31:0] STAT_ADDR   = 32'h4000_3800
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [31:0]       req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_write_i,
  input  logic              req_priv_i,
  input  logic              reg_wr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic              req_err_o,
  output logic              fault_o,
  output logic [STAT_W-1:0] status_o
);
  map_hit_t           hit;
  logic [CAUSE_W-1:0] cause;

  bfc_decode #(
    .FLASH_BASE(FLASH_BASE), .FLASH_WIN(FLASH_WIN), .FLASH_SIZE(FLASH_SIZE),
    .RAM_BASE(RAM_BASE), .RAM_WIN(RAM_WIN), .RAM_SIZE(RAM_SIZE),
    .PROT_BASE(PROT_BASE), .PROT_SIZE(PROT_SIZE),
    .PERIPH_BASE(PERIPH_BASE), .WIN_BLKS(WIN_BLKS), .NUM_BLK(NUM_BLK),
    .LAST_OFS(LAST_OFS), .SYS_MASK(SYS_MASK),
    .SYS_BASE(SYS_BASE), .SYS_SIZE(SYS_SIZE), .STAT_ADDR(STAT_ADDR)
  ) u_decode (
    .addr_i (req_addr_i),
    .hit_o  (hit)
  );

  bfc_classify u_classify (
    .valid_i   (req_valid_i),
    .size_i    (req_size_i),
    .addr_lo_i (req_addr_i[1:0]),
    .write_i   (req_write_i),
    .priv_i    (req_priv_i),
    .hit_i     (hit),
    .cause_o   (cause)
  );

  bfc_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cause_i    (cause),
    .clr_en_i   (reg_wr_i),
    .clr_mask_i (reg_wdata_i),
    .status_o   (status_o),
    .fault_o    (fault_o)
  );

  assign req_err_o = |cause;
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter logic [31:0] STAT_ADDR = 32'h4000_3800
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_addr_i,
  input logic        req_write_i,
  input logic        reg_wr_i,
  input logic [3:0]  reg_wdata_i,
  input logic        req_err_o,
  input logic        fault_o,
  input logic [3:0]  status_o
);
  AST_ERR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !req_err_o); // R11
  AST_FAULT_FOLLOWS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |=> fault_o); // R9
  AST_NO_FAULT_WITHOUT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_err_o |=> !fault_o); // R9
  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (status_o[2:0] != 3'b000)); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> (($past(status_o) & ~status_o) == 4'b0000)); // R8
  AST_CLEAR_ONLY_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> ((($past(status_o) & ~$past(reg_wdata_i)) & ~status_o) == 4'b0000)); // R8
  AST_MISSED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_err_o && (status_o[2:0] != 3'b000)) |=> status_o[3]); // R7
  AST_QUIET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_err_o && !reg_wr_i) |=> $stable(status_o)); // R11
  AST_STAT_READ_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i == STAT_ADDR) |-> !req_err_o); // R10
endmodule

bind bus_fault_chk bfc_checker #(.STAT_ADDR(STAT_ADDR)) u_bfc_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_addr_i  (req_addr_i),
  .req_write_i (req_write_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .req_err_o   (req_err_o),
  .fault_o     (fault_o),
  .status_o    (status_o)
);

// File: tb/sim_bus_fault_chk.sv
`timescale 1ns/1ps
module sim_bus_fault_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_wdata = '0;
  logic        req_err, fault;
  logic [3:0]  status;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bus_fault_chk u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_write_i(req_write), .req_priv_i(req_priv),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .req_err_o(req_err), .fault_o(fault), .status_o(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one access: err sampled mid-cycle, status and pulse after the edge
  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                     input logic pv, input logic exp_err, input logic [3:0] exp_st,
                     input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_priv = pv;
    #5 chk({tag, " err"}, 32'(req_err), 32'(exp_err));
    @(posedge clk);
    #2 chk({tag, " fault"}, 32'(fault), 32'(exp_err));
    chk({tag, " status"}, 32'(status), 32'(exp_st));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic clr(input logic [3:0] m, input logic [3:0] exp_st, input string tag);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = m;
    @(posedge clk);
    #2 chk({tag, " clr status"}, 32'(status), 32'(exp_st));
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    chk("R11 reset status", 32'(status), 0);
    chk("R11 reset fault", 32'(fault), 0);
    chk("R11 idle err", 32'(req_err), 0);
  endtask

  task automatic t_legal;
    acc(32'h0800_0000, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0, "R11 flash read");
    acc(32'h2000_0100, 2'd2, 1'b1, 1'b0, 1'b0, 4'h0, "R11 ram write unpriv");
    acc(32'h2000_0101, 2'd0, 1'b1, 1'b0, 1'b0, 4'h0, "R11 ram byte write");
    acc(32'h4000_0020, 2'd2, 1'b1, 1'b1, 1'b0, 4'h0, "R4 last reg ok");
    acc(32'h2000_3FFC, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0, "R5 ram top word ok");
  endtask

  task automatic t_size;
    acc(32'h4000_0010, 2'd0, 1'b0, 1'b1, 1'b1, 4'h1, "R1 apb byte");
    clr(4'hF, 4'h0, "R8");
    acc(32'h4000_2010, 2'd1, 1'b1, 1'b1, 1'b1, 4'h1, "R1 apb half");
    clr(4'hF, 4'h0, "R8");
    acc(32'h2000_0102, 2'd2, 1'b0, 1'b1, 1'b1, 4'h1, "R2 ram unaligned");
    clr(4'h1, 4'h0, "R8");
  endtask

  task automatic t_prot;
    acc(32'h4000_1000, 2'd2, 1'b1, 1'b0, 1'b1, 4'h2, "R3 sys apb write");
    clr(4'h2, 4'h0, "R8");
    acc(32'h4000_1000, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0, "R3 sys apb read");
    acc(32'h4000_1000, 2'd2, 1'b1, 1'b1, 1'b0, 4'h0, "R3 priv write");
    acc(32'hE000_0010, 2'd2, 1'b1, 1'b0, 1'b1, 4'h2, "R3 ahb sys write");
    clr(4'h2, 4'h0, "R8");
    acc(32'h2000_3004, 2'd2, 1'b1, 1'b0, 1'b1, 4'h2, "R3 prot ram write");
    clr(4'h2, 4'h0, "R8");
  endtask

  task automatic t_rsvd;
    acc(32'h4000_0024, 2'd2, 1'b0, 1'b1, 1'b1, 4'h4, "R4 past last reg");
    clr(4'h4, 4'h0, "R8");
    acc(32'h4000_5000, 2'd2, 1'b0, 1'b1, 1'b1, 4'h4, "R4 missing block");
    clr(4'h4, 4'h0, "R8");
    acc(32'h0802_0000, 2'd2, 1'b0, 1'b1, 1'b1, 4'h4, "R5 above flash");
    clr(4'h4, 4'h0, "R8");
    acc(32'h2000_4000, 2'd2, 1'b0, 1'b1, 1'b1, 4'h4, "R5 above ram");
    clr(4'h4, 4'h0, "R8");
  endtask

  task automatic t_multi_missed;
    acc(32'h4000_1080, 2'd0, 1'b1, 1'b0, 1'b1, 4'h7, "R6 three causes");
    acc(32'h4000_0000, 2'd0, 1'b0, 1'b1, 1'b1, 4'hF, "R7 second fault");
    clr(4'h8, 4'h7, "R8 clear missed only");
    clr(4'h7, 4'h0, "R8 clear rest");
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h4000_0004; req_size = 2'd0;
    req_write = 1'b0; req_priv = 1'b1;
    reg_wr = 1'b1; reg_wdata = 4'h1;
    @(posedge clk);
    #2 chk("R8 set beats clear", 32'(status), 32'h1);
    @(negedge clk);
    req_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    @(posedge clk);
    #2 chk("R9 pulse ends", 32'(fault), 0);
    chk("R8 held after", 32'(status), 32'h1);
    clr(4'h1, 4'h0, "R8");
  endtask

  task automatic t_stat;
    acc(32'h4000_3800, 2'd0, 1'b0, 1'b0, 1'b0, 4'h0, "R10 byte read of status");
    acc(32'h4000_3800, 2'd2, 1'b0, 1'b0, 1'b0, 4'h0, "R10 word read of status");
    acc(32'h4000_3800, 2'd0, 1'b1, 1'b1, 1'b1, 4'h5, "R10 write not exempt");
    clr(4'hF, 4'h0, "R8");
  endtask

  initial begin : watchdog
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_legal();
    t_size();
    t_prot();
    t_rsvd();
    t_multi_missed();
    t_set_wins();
    t_stat();
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule